// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of serial transfers held in its own queue memory, with no processor help between entries. The queue has 32 entries. Each entry holds a 16-bit word to send, a 16-bit word that receives the reply, and a command byte. The command byte gives the levels of four peripheral select outputs and a flag that keeps those selects asserted into the next entry. The host reads and writes the queue and a small set of control registers through a plain memory-mapped port.

The host writes a start index, an end index and a clock divisor, then sets the run bit. The controller steps a queue pointer from the start index towards the end index. It shifts one 16-bit word per entry and waits a fixed 17 system clocks between entries. Without wrap it raises a sticky done flag after the end entry and stops. With wrap it goes back to the start index and keeps refreshing the receive words. The host may rewrite the pointer at any time to move execution to another segment of the queue. Clearing the run bit stops the controller once the current entry has finished.

Top module: `qspi_queue_master`

## Requirements
- R1: After a synchronous active-low reset, spi_cs is 4'b1111 (the idle level), spi_sck and spi_mosi are 0, q_done and q_busy are 0 and q_ptr is 0.
- R2: host_addr[6:5] selects an area: 0 is receive, 1 is transmit, 2 is command and 3 is registers. host_addr[4:0] picks the entry. The register offsets in host_addr[2:0] are: 0 control (bit0 run, bit1 wrap), 1 start index, 2 end index, 3 status (bit0 done, bit1 busy), 4 pointer and 5 clock divisor. Read data appears on host_rdata one clock after the address. Command bits [7:5] always read as zero.
- R3: Each entry shifts 16 bits, most significant bit first. SCK idles low. MOSI changes on falling edges and MISO is sampled on rising edges. The received word is stored in the receive area of that entry.
- R4: SCK stays high and stays low for divisor/2 system clocks each (at least 1), where divisor is the value in register 5 (reset value 4).
- R5: While an entry shifts, spi_cs equals bits [3:0] of that entry's command byte.
- R6: Entries run in order from the start index to the end index, and the pointer advances by one after each completed entry. After the run ends, q_ptr holds the start index.
- R7: Without wrap, q_done is set after the end entry completes. The controller then goes idle with spi_cs idle and q_busy low. Writing 1 to status bit0 clears q_done.
- R8: With wrap set, the end entry is followed by the start entry, and each new received word overwrites the older one in the receive area.
- R9: Between entries, spi_cs keeps the finished entry's pattern when command bit4 (continue) of that entry is 1, and goes to the idle level when it is 0.
- R10: From the last SCK falling edge of one entry to the first SCK rising edge of the next, exactly 17 + divisor/2 system clocks pass.
- R11: A host write to the pointer register takes effect at once on q_ptr, and the next entry is taken from the written index.
- R12: Writing control with run = 0 while busy stops the controller after the current entry. q_done is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 7 | Host address (area and entry, or register offset) |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one clock after the address |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Peripheral select levels |
| q_done | output | 1 | Sticky queue-complete flag |
| q_busy | output | 1 | Controller is executing the queue |
| q_ptr | output | 5 | Current queue pointer |

## Verification
The bench checks the gap between entries to the exact clock count. A gap that is off by one register stage would show a spacing of 16 or 18 plus the half period. It checks select levels during the gap in both settings of the continue flag, so a design that ignores the flag, or drops the selects one clock late, leaves a wrong pattern a few clocks after the last fall. A pointer rewrite in the middle of an entry must send execution to the new segment. A design that advances the pointer over the host's value would run entry 1 instead of entry 20. The wrap run is stopped by clearing run, and the check requires that the word sequence repeats the segment, that the newest receive words are the ones kept, and that no done flag appears.

// File: rtl/qspi_pkg.sv
// Package: shared encodings for the queued SPI master.
// Assumes: host address area codes and register offsets are fixed by the brief.
package qspi_pkg;

    // Host address area, taken from the two top address bits
    typedef enum logic [1:0] {
        AREA_RX  = 2'd0,
        AREA_TX  = 2'd1,
        AREA_CMD = 2'd2,
        AREA_REG = 2'd3
    } area_e;

    // Register offsets inside the register area
    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_START = 3'd1,
        REG_END   = 3'd2,
        REG_STAT  = 3'd3,
        REG_PTR   = 3'd4,
        REG_DIV   = 3'd5
    } reg_e;

    // Queue sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_SHIFT,
        SQ_GAP
    } sq_state_e;

endpackage

// File: rtl/qspi_queue_mem.sv
// Module: queue storage holding the receive, transmit and command areas.
// The host port and the engine port are not arbitrated. If both write the same
// receive entry in one clock, the engine's write wins. Reads are combinational.
// Assumes: DEPTH is a power of two.
module qspi_queue_mem
    import qspi_pkg::*;
#(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CMD_W  = 5,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              h_wr,
    input  area_e             h_area,
    input  logic [IDX_W-1:0]  h_idx,
    input  logic [WORD_W-1:0] h_wdata,
    output logic [WORD_W-1:0] h_rx,
    output logic [WORD_W-1:0] h_tx,
    output logic [CMD_W-1:0]  h_cmd,
    input  logic [IDX_W-1:0]  e_idx,
    output logic [WORD_W-1:0] e_tx,
    output logic [CMD_W-1:0]  e_cmd,
    input  logic              e_rx_we,
    input  logic [IDX_W-1:0]  e_rx_idx,
    input  logic [WORD_W-1:0] e_rx_data
);

    logic [WORD_W-1:0] rx_mem  [DEPTH];
    logic [WORD_W-1:0] tx_mem  [DEPTH];
    logic [CMD_W-1:0]  cmd_mem [DEPTH];

    // Transmit and command areas: host writes only
    always_ff @(posedge clk) begin
        if (h_wr && h_area == AREA_TX)  tx_mem[h_idx]  <= h_wdata;
        if (h_wr && h_area == AREA_CMD) cmd_mem[h_idx] <= h_wdata[CMD_W-1:0];
    end

    // Receive area: host write first, engine write last so the engine wins
    always_ff @(posedge clk) begin
        if (h_wr && h_area == AREA_RX) rx_mem[h_idx] <= h_wdata;
        if (e_rx_we)                   rx_mem[e_rx_idx] <= e_rx_data;
    end

    assign h_rx  = rx_mem[h_idx];
    assign h_tx  = tx_mem[h_idx];
    assign h_cmd = cmd_mem[h_idx];
    assign e_tx  = tx_mem[e_idx];
    assign e_cmd = cmd_mem[e_idx];

endmodule

// File: rtl/qspi_bit_engine.sv
// Module: serial shifter for one entry. SCK idles low. MOSI changes on falling
// edges and MISO is sampled on rising edges, MSB first.
// On load it takes a word and makes WORD_W clock pulses of half-period `half`.
// It pulses word_done for one clock, one clock after the last falling edge.
// Assumes: half >= 1 and stays constant during a word.
module qspi_bit_engine #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned HW     = 7,
    localparam int unsigned BC_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [HW-1:0]     half,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word
);

    logic [WORD_W-1:0] sh_tx;
    logic [HW-1:0]     hcnt;
    logic [BC_W-1:0]   bcnt;
    logic              active;
    logic              edge_now;
    logic              last_fall;

    assign edge_now  = active && (hcnt == half - HW'(1));
    assign last_fall = edge_now && sck && (bcnt == BC_W'(WORD_W - 1));

    // SCK generation, bit shifting and receive sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_tx   <= '0;
            rx_word <= '0;
            hcnt    <= '0;
            bcnt    <= '0;
            active  <= 1'b0;
            sck     <= 1'b0;
        end else if (load) begin
            sh_tx  <= tx_word;
            hcnt   <= '0;
            bcnt   <= '0;
            active <= 1'b1;
            sck    <= 1'b0;
        end else if (active) begin
            if (edge_now) begin
                hcnt <= '0;
                sck  <= ~sck;
                if (!sck) begin
                    rx_word <= {rx_word[WORD_W-2:0], miso};
                end else begin
                    bcnt <= bcnt + BC_W'(1);
                    if (last_fall) active <= 1'b0;
                    else           sh_tx  <= {sh_tx[WORD_W-2:0], 1'b0};
                end
            end else begin
                hcnt <= hcnt + HW'(1);
            end
        end
    end

    // One-clock completion pulse, issued after the last falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) word_done <= 1'b0;
        else        word_done <= last_fall;
    end

    assign mosi = active ? sh_tx[WORD_W-1] : 1'b0;

endmodule

// File: rtl/qspi_sequencer.sv
// Module: queue walker. It loads each entry, drives the selects, writes back
// the received word, picks the next pointer (advance, wrap or host override)
// and inserts the fixed gap between entries.
// Assumes: GAP_CLKS >= 3. The gap counts from the last SCK fall to the next
// entry's load edge.
module qspi_sequencer
    import qspi_pkg::*;
#(
    parameter int unsigned DEPTH    = 32,
    parameter int unsigned CS_W     = 4,
    parameter int unsigned GAP_CLKS = 17,
    parameter logic [CS_W-1:0] CS_IDLE = '1,
    localparam int unsigned IDX_W    = $clog2(DEPTH),
    localparam int unsigned GC_W     = $clog2(GAP_CLKS),
    localparam int unsigned GAP_LAST = GAP_CLKS - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             run,
    input  logic             wrap,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] end_idx,
    input  logic             ptr_wr,
    input  logic [IDX_W-1:0] ptr_wdata,
    input  logic [CS_W:0]    e_cmd,
    input  logic             word_done,
    output logic             busy,
    output logic [IDX_W-1:0] qptr,
    output logic [IDX_W-1:0] act_idx,
    output logic             load,
    output logic             rx_we,
    output logic [CS_W-1:0]  cs,
    output logic             done_set,
    output logic             finish
);

    sq_state_e        state;
    logic [GC_W-1:0]  gcnt;
    logic             cont_q;
    logic             redirect;
    logic             redirect_eff;
    logic             last;
    logic             entry_end;

    assign redirect_eff = redirect || ptr_wr;
    assign last         = (act_idx == end_idx);
    assign entry_end    = (state == SQ_SHIFT) && word_done;
    assign done_set     = entry_end && last && !wrap && !redirect_eff;
    assign finish       = done_set || (entry_end && !run);
    assign rx_we        = entry_end;
    assign load         = (state == SQ_LOAD);
    assign busy         = (state != SQ_IDLE);

    // State, pointer, select and gap bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            gcnt     <= '0;
            qptr     <= '0;
            act_idx  <= '0;
            cs       <= CS_IDLE;
            cont_q   <= 1'b0;
            redirect <= 1'b0;
        end else begin
            if (ptr_wr) begin
                qptr     <= ptr_wdata;
                redirect <= (state != SQ_IDLE);
            end
            case (state)
                SQ_IDLE: begin
                    if (go) begin
                        qptr     <= start_idx;
                        redirect <= 1'b0;
                        state    <= SQ_LOAD;
                    end
                end
                SQ_LOAD: begin
                    act_idx  <= qptr;
                    cs       <= e_cmd[CS_W-1:0];
                    cont_q   <= e_cmd[CS_W];
                    redirect <= ptr_wr;
                    state    <= SQ_SHIFT;
                end
                SQ_SHIFT: begin
                    if (word_done) begin
                        if (!redirect_eff) qptr <= last ? start_idx : act_idx + IDX_W'(1);
                        if (finish) begin
                            cs    <= CS_IDLE;
                            state <= SQ_IDLE;
                        end else begin
                            if (!cont_q) cs <= CS_IDLE;
                            gcnt  <= '0;
                            state <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: begin
                    if (gcnt == GC_W'(GAP_LAST)) state <= SQ_LOAD;
                    else                         gcnt  <= gcnt + GC_W'(1);
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/qspi_queue_master.sv
// Module: top of the queued SPI master. It holds the host-visible control
// registers and the registered read mux, and joins the queue memory,
// sequencer and bit engine together.
// Assumes: DEPTH >= 8, so that register offsets fit in the entry index bits.
module qspi_queue_master
    import qspi_pkg::*;
#(
    parameter int unsigned DEPTH     = 32,
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned CS_W      = 4,
    parameter int unsigned GAP_CLKS  = 17,
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned DIV_RESET = 4,
    parameter logic [CS_W-1:0] CS_IDLE = '1,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned ADDR_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [CS_W-1:0]   spi_cs,
    output logic              q_done,
    output logic              q_busy,
    output logic [IDX_W-1:0]  q_ptr
);

    localparam int unsigned CMD_W = CS_W + 1;
    localparam int unsigned HW    = DIV_W - 1;

    area_e             h_area;
    reg_e              h_reg;
    logic [IDX_W-1:0]  h_idx;
    logic              reg_wr;
    logic              go;
    logic              ptr_wr;

    logic              run_q;
    logic              wrap_q;
    logic [IDX_W-1:0]  start_q;
    logic [IDX_W-1:0]  end_q;
    logic [DIV_W-1:0]  div_q;
    logic [HW-1:0]     half_eff;

    logic [WORD_W-1:0] m_rx;
    logic [WORD_W-1:0] m_tx;
    logic [CMD_W-1:0]  m_cmd;
    logic [WORD_W-1:0] e_tx;
    logic [CMD_W-1:0]  e_cmd;
    logic [IDX_W-1:0]  act_idx;
    logic              seq_load;
    logic              rx_we;
    logic              done_set;
    logic              finish;
    logic              word_done;
    logic [WORD_W-1:0] rx_word;

    assign h_area   = area_e'(host_addr[ADDR_W-1 -: 2]);
    assign h_reg    = reg_e'(host_addr[2:0]);
    assign h_idx    = host_addr[IDX_W-1:0];
    assign reg_wr   = host_wr && (h_area == AREA_REG);
    assign go       = reg_wr && (h_reg == REG_CTRL) && host_wdata[0] && !q_busy;
    assign ptr_wr   = reg_wr && (h_reg == REG_PTR);
    assign half_eff = (div_q[DIV_W-1:1] == '0) ? HW'(1) : div_q[DIV_W-1:1];

    // Control registers; the sequencer's finish and done events beat host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            wrap_q  <= 1'b0;
            start_q <= '0;
            end_q   <= '0;
            div_q   <= DIV_W'(DIV_RESET);
            q_done  <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (h_reg)
                    REG_CTRL: begin
                        run_q  <= host_wdata[0];
                        wrap_q <= host_wdata[1];
                    end
                    REG_START: start_q <= host_wdata[IDX_W-1:0];
                    REG_END:   end_q   <= host_wdata[IDX_W-1:0];
                    REG_STAT:  if (host_wdata[0]) q_done <= 1'b0;
                    REG_DIV:   div_q   <= host_wdata[DIV_W-1:0];
                    default: ;
                endcase
            end
            if (finish)   run_q  <= 1'b0;
            if (done_set) q_done <= 1'b1;
        end
    end

    // Registered host read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else begin
            case (h_area)
                AREA_RX:  host_rdata <= m_rx;
                AREA_TX:  host_rdata <= m_tx;
                AREA_CMD: host_rdata <= WORD_W'(m_cmd);
                default: begin
                    case (h_reg)
                        REG_CTRL:  host_rdata <= WORD_W'({wrap_q, run_q});
                        REG_START: host_rdata <= WORD_W'(start_q);
                        REG_END:   host_rdata <= WORD_W'(end_q);
                        REG_STAT:  host_rdata <= WORD_W'({q_busy, q_done});
                        REG_PTR:   host_rdata <= WORD_W'(q_ptr);
                        REG_DIV:   host_rdata <= WORD_W'(div_q);
                        default:   host_rdata <= '0;
                    endcase
                end
            endcase
        end
    end

    qspi_queue_mem #(
        .DEPTH (DEPTH),
        .WORD_W(WORD_W),
        .CMD_W (CMD_W)
    ) u_mem (
        .clk      (clk),
        .h_wr     (host_wr),
        .h_area   (h_area),
        .h_idx    (h_idx),
        .h_wdata  (host_wdata),
        .h_rx     (m_rx),
        .h_tx     (m_tx),
        .h_cmd    (m_cmd),
        .e_idx    (q_ptr),
        .e_tx     (e_tx),
        .e_cmd    (e_cmd),
        .e_rx_we  (rx_we),
        .e_rx_idx (act_idx),
        .e_rx_data(rx_word)
    );

    qspi_sequencer #(
        .DEPTH   (DEPTH),
        .CS_W    (CS_W),
        .GAP_CLKS(GAP_CLKS),
        .CS_IDLE (CS_IDLE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .run      (run_q),
        .wrap     (wrap_q),
        .start_idx(start_q),
        .end_idx  (end_q),
        .ptr_wr   (ptr_wr),
        .ptr_wdata(host_wdata[IDX_W-1:0]),
        .e_cmd    (e_cmd),
        .word_done(word_done),
        .busy     (q_busy),
        .qptr     (q_ptr),
        .act_idx  (act_idx),
        .load     (seq_load),
        .rx_we    (rx_we),
        .cs       (spi_cs),
        .done_set (done_set),
        .finish   (finish)
    );

    qspi_bit_engine #(
        .WORD_W(WORD_W),
        .HW    (HW)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .tx_word  (e_tx),
        .half     (half_eff),
        .miso     (spi_miso),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .word_done(word_done),
        .rx_word  (rx_word)
    );

endmodule

// File: rtl/qspi_queue_master_chk.sv
// Module: protocol checker for the queued SPI master, bound to the top.
// Assumes: the selects and SCK are observed at the top ports.
module qspi_queue_master_chk #(
    parameter int unsigned CS_W = 4,
    parameter logic [CS_W-1:0] CS_IDLE = '1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sck,
    input logic            mosi,
    input logic [CS_W-1:0] cs,
    input logic            busy,
    input logic            done
);

    // R1: reset brings every output to its idle level
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (cs == CS_IDLE && !sck && !busy && !done));

    // R5: the select pattern never moves while SCK is high
    a_r5_cs_steady_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(cs));

    // R3: MOSI is already settled when SCK rises
    a_r3_mosi_settled_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));

    // R7: when idle, the selects are released and SCK is low
    a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs == CS_IDLE && !sck));

    // R7: done rises together with the return to idle
    a_r7_done_means_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);

endmodule

bind qspi_queue_master qspi_queue_master_chk #(
    .CS_W   (CS_W),
    .CS_IDLE(CS_IDLE)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .sck  (spi_sck),
    .mosi (spi_mosi),
    .cs   (spi_cs),
    .busy (q_busy),
    .done (q_done)
);

// File: tb/qspi_queue_master_tb.sv
module qspi_queue_master_tb;

    localparam int RXA = 'h00, TXA = 'h20, CMDA = 'h40, REGA = 'h60;
    localparam int GAP = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [3:0]  spi_cs;
    logic        q_done, q_busy;
    logic [4:0]  q_ptr;

    always #2 clk = ~clk;

    qspi_queue_master u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs),
        .q_done(q_done), .q_busy(q_busy), .q_ptr(q_ptr)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Bench copies of what the host wrote
    logic [15:0] tx_model  [32];
    logic [7:0]  cmd_model [32];

    // Slave model state
    logic [15:0] miso_words [512];
    logic [15:0] mosi_seen  [512];
    logic [3:0]  cs_seen    [512];
    logic [3:0]  gcs_seen   [512];
    int          gap_seen   [512];
    int          hi_seen    [512];
    int          nrx = 0, mbit = 0, ment = 0, cyc = 0;
    int          last_fall = 0, last_rise = 0, since_end = -1;
    logic        prev_sck = 1'b0;
    logic [15:0] msh = '0;

    assign spi_miso = miso_words[ment][15 - mbit];

    // SPI slave: samples MOSI on rises, moves MISO on falls, records timing
    always @(negedge clk) begin
        cyc++;
        if (spi_sck && !prev_sck) begin
            if (mbit == 0) begin
                cs_seen[nrx]  = spi_cs;
                gap_seen[nrx] = cyc - last_fall;
            end
            msh = {msh[14:0], spi_mosi};
            last_rise = cyc;
        end
        if (!spi_sck && prev_sck) begin
            last_fall = cyc;
            if (mbit == 15) begin
                mosi_seen[nrx] = msh;
                hi_seen[nrx]   = cyc - last_rise;
                nrx++;
                ment++;
                mbit = 0;
                since_end = 0;
            end else begin
                mbit++;
            end
        end
        if (since_end >= 0) begin
            since_end++;
            if (since_end == 4) begin
                gcs_seen[nrx-1] = spi_cs;
                since_end = -1;
            end
        end
        prev_sck = spi_sck;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input int a, input int d);
        @(negedge clk);
        host_addr = 7'(a); host_wdata = 16'(d); host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(input int a, output logic [15:0] d);
        @(negedge clk);
        host_addr = 7'(a);
        @(negedge clk);
        d = host_rdata;
    endtask

    function automatic int half_of(input int div);
        return (div / 2 < 1) ? 1 : div / 2;
    endfunction

    task automatic fill_entry(input int idx);
        tx_model[idx]  = 16'($urandom);
        cmd_model[idx] = {3'b000, 5'($urandom)};
        hwr(TXA + idx, tx_model[idx]);
        hwr(CMDA + idx, cmd_model[idx]);
    endtask

    // One run without wrap from s to e, checked entry by entry
    task automatic run_check(input int s, input int e, input int div);
        int base, n, h;
        logic [15:0] d;
        base = nrx; n = e - s + 1; h = half_of(div);
        for (int i = 0; i < n; i++) begin
            fill_entry(s + i);
            miso_words[base + i] = 16'($urandom);
        end
        hwr(REGA + 5, div);
        hwr(REGA + 1, s);
        hwr(REGA + 2, e);
        hwr(REGA + 0, 1);
        while (!q_done) @(negedge clk);
        check(nrx - base == n, "R6 entry count", nrx - base, n);
        check(q_ptr == 5'(s), "R6 pointer back at start", q_ptr, s);
        check(!q_busy && spi_cs == 4'hF, "R7 idle after done", {q_busy, spi_cs}, 'hF);
        for (int i = 0; i < n; i++) begin
            check(mosi_seen[base+i] == tx_model[s+i], "R3 mosi word", mosi_seen[base+i], tx_model[s+i]);
            check(cs_seen[base+i] == cmd_model[s+i][3:0], "R5 select pattern", cs_seen[base+i], cmd_model[s+i][3:0]);
            check(hi_seen[base+i] == h, "R4 sck high time", hi_seen[base+i], h);
            if (i > 0)
                check(gap_seen[base+i] == GAP + h, "R10 entry gap", gap_seen[base+i], GAP + h);
            if (i < n - 1)
                check(gcs_seen[base+i] == (cmd_model[s+i][4] ? cmd_model[s+i][3:0] : 4'hF),
                      "R9 selects in gap", gcs_seen[base+i],
                      cmd_model[s+i][4] ? cmd_model[s+i][3:0] : 4'hF);
            hrd(RXA + s + i, d);
            check(d == miso_words[base+i], "R3 receive word stored", d, miso_words[base+i]);
        end
        hwr(REGA + 3, 1);
        @(negedge clk);
        check(!q_done, "R7 done cleared by write-one", q_done, 0);
    endtask

    initial begin
        logic [15:0] d;
        int base, m, s, n, divs[3];
        void'($urandom(32'h1A2B3C4D));
        divs = '{2, 4, 6};
        for (int i = 0; i < 512; i++) miso_words[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(spi_cs == 4'hF, "R1 cs idle", spi_cs, 'hF);
        check(!spi_sck && !spi_mosi, "R1 sck/mosi low", {spi_sck, spi_mosi}, 0);
        check(!q_done && !q_busy && q_ptr == 0, "R1 status", {q_done, q_busy, q_ptr}, 0);
        hrd(REGA + 5, d);
        check(d == 4, "R4 divisor reset value", d, 4);

        // R2 memory access and reserved command bits
        hwr(TXA + 9, 'hBEEF);  hrd(TXA + 9, d);  check(d == 'hBEEF, "R2 tx readback", d, 'hBEEF);
        hwr(RXA + 31, 'h1234); hrd(RXA + 31, d); check(d == 'h1234, "R2 rx readback", d, 'h1234);
        hwr(CMDA + 3, 'hFF);   hrd(CMDA + 3, d); check(d == 'h1F, "R2 cmd reserved bits zero", d, 'h1F);
        hwr(REGA + 2, 7);      hrd(REGA + 2, d); check(d == 7, "R2 end index register", d, 7);

        // Directed corner cases: single entry, full span edges, slowest/fastest clock
        run_check(0, 0, 2);
        run_check(29, 31, 6);
        // Random runs
        for (int r = 0; r < 6; r++) begin
            n = 1 + ($urandom % 5);
            s = $urandom % (33 - n);
            run_check(s, s + n - 1, divs[$urandom % 3]);
        end

        // R8 wrap, then R12 stop by clearing run
        base = nrx;
        for (int i = 2; i <= 4; i++) fill_entry(i);
        for (int k = 0; k < 12; k++) miso_words[base + k] = 16'($urandom);
        hwr(REGA + 5, 2);
        hwr(REGA + 1, 2);
        hwr(REGA + 2, 4);
        hwr(REGA + 0, 3);
        while (nrx - base < 7) @(negedge clk);
        hwr(REGA + 0, 2);
        while (q_busy) @(negedge clk);
        m = nrx - base;
        check(m >= 7 && m <= 9, "R12 stops after current entry", m, 8);
        check(!q_done, "R12 no done on stop", q_done, 0);
        for (int k = 0; k < m; k++)
            check(mosi_seen[base+k] == tx_model[2 + (k % 3)], "R8 wrap order", mosi_seen[base+k], tx_model[2 + (k % 3)]);
        for (int j = 2; j <= 4; j++) begin
            int last_k;
            last_k = -1;
            for (int k = 0; k < m; k++) if (2 + (k % 3) == j) last_k = k;
            hrd(RXA + j, d);
            check(d == miso_words[base + last_k], "R8 newest receive kept", d, miso_words[base + last_k]);
        end

        // R11 pointer rewrite during the first entry
        base = nrx;
        fill_entry(0);
        for (int i = 20; i <= 22; i++) fill_entry(i);
        for (int k = 0; k < 4; k++) miso_words[base + k] = 16'($urandom);
        hwr(REGA + 5, 4);
        hwr(REGA + 1, 0);
        hwr(REGA + 2, 22);
        hwr(REGA + 0, 1);
        while (!spi_sck) @(negedge clk);
        hwr(REGA + 4, 20);
        check(q_ptr == 20, "R11 pointer written", q_ptr, 20);
        while (!q_done) @(negedge clk);
        check(nrx - base == 4, "R11 redirected count", nrx - base, 4);
        check(mosi_seen[base] == tx_model[0], "R11 first entry", mosi_seen[base], tx_model[0]);
        for (int k = 1; k < 4; k++)
            check(mosi_seen[base+k] == tx_model[19 + k], "R11 new segment", mosi_seen[base+k], tx_model[19 + k]);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule